// File: doc/BRIEF.md
# Floating-Point Register Load/Store Sequencer

This block moves data between a 32-entry file of 32-bit floating-point registers and a word-addressed data memory, one instruction at a time. The caller presents a 32-bit instruction word with a one-cycle start strobe. The block decodes the direction (load or store), the address form (signed immediate offset or register-indexed), the transfer width (one, two or four 32-bit words) and the auto-increment request. It reads the integer base and index registers and computes one effective address. It then moves one 32-bit word per cycle over an aligned group of floating-point registers.

The integer register file, the floating-point register file and the data memory are all outside the block. They are reached through combinational-read ports and synchronous-write strobes. When auto-increment is requested, the block writes the effective address back into the integer base register once, in the cycle where it pulses done. A write-back to register 0 is suppressed.

Top module: `fpls_seq`

## Requirements
- R1: After synchronous reset, busy and done are low and none of the write strobes (mem_we, fp_we, int_we) is asserted.
- R2: Opcode field instr[31:26] = 0x08 or 0x09 loads words from memory into floating-point registers. 0x0a or 0x0b stores floating-point registers to memory. For both directions the register number is instr[20:16].
- R3: An odd opcode forms the address as integer register instr[25:21] plus the sign-extended instr[15:0], after that offset's low bits are cleared to a multiple of the transfer size. An even opcode forms it as register instr[25:21] plus register instr[15:11].
- R4: Size flags in the instruction's low bits: instr[1]=1 selects one word (4 bytes); instr[1]=0 with instr[2]=1 selects four words (16 bytes); instr[1]=0 with instr[2]=0 selects two words (8 bytes). No word outside that count is touched.
- R5: Word i of a transfer uses floating-point register (instr[20:16] with its low bit cleared for two words, low two bits cleared for four) plus i, at byte address EA + 4*i. Words go in ascending order, one per cycle.
- R6: A start that is accepted in the idle state raises busy in the next cycle. The last word moves n+1 cycles after the accepting edge, where n is the word count. Done is high for exactly one cycle after the last word, and busy falls with it.
- R7: A start strobe that arrives while a transfer is in progress is ignored.
- R8: With instr[0]=1, the effective address is written to integer register instr[25:21] exactly once, in the done cycle. With instr[0]=0 there is no integer write.
- R9: The auto-increment write-back is suppressed when the base register number is 0.
- R10: A start strobe with any opcode other than 0x08 to 0x0b is ignored, and the block stays idle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a transfer with instr (accepted only when idle) |
| instr | input | 32 | Instruction word |
| busy | output | 1 | A transfer is in progress |
| done | output | 1 | One-cycle pulse after the last word |
| int_ra_base | output | 5 | Integer read address, base register |
| int_ra_idx | output | 5 | Integer read address, index register |
| int_rd_base | input | XLEN | Base register value |
| int_rd_idx | input | XLEN | Index register value |
| int_we | output | 1 | Integer write strobe (auto-increment) |
| int_waddr | output | 5 | Integer write register |
| int_wdata | output | XLEN | Integer write data (effective address) |
| fp_raddr | output | 5 | Floating-point read address (stores) |
| fp_rdata | input | XLEN | Floating-point read data |
| fp_we | output | 1 | Floating-point write strobe (loads) |
| fp_waddr | output | 5 | Floating-point write register |
| fp_wdata | output | XLEN | Floating-point write data |
| mem_addr | output | XLEN | Byte address of the current word |
| mem_we | output | 1 | Memory write strobe (stores) |
| mem_wdata | output | XLEN | Memory write data |
| mem_rdata | input | XLEN | Memory read data for mem_addr |

## Verification
The bench targets the immediate offsets whose low flag bits must be cleared before the add, including a negative offset. A design that kept those bits would place the words a few bytes off and fail the data comparison. It also uses odd destination registers for two- and four-word transfers, where a design that skips group alignment writes the wrong registers, and it checks the word just past each transfer to catch a wrong size decode. It drives auto-increment with base register 0, a start held high during a transfer, and an unknown opcode. A faulty design would write r0, start a second transfer, or go busy.

// File: rtl/fpls_pkg.sv
package fpls_pkg;
  localparam int RIDX_W = 5;

  localparam logic [5:0] OP_FLD_IDX = 6'h08;
  localparam logic [5:0] OP_FLD_IMM = 6'h09;
  localparam logic [5:0] OP_FST_IDX = 6'h0a;
  localparam logic [5:0] OP_FST_IMM = 6'h0b;

  typedef enum logic [1:0] {ST_IDLE, ST_ADDR, ST_XFER, ST_FIN} fpls_state_e;
  typedef enum logic [1:0] {SZ_WORD, SZ_PAIR, SZ_QUAD} fpls_size_e;

  typedef struct packed {
    logic              store;
    logic              imm_form;
    logic              autoinc;
    logic [RIDX_W-1:0] base_reg;
    logic [RIDX_W-1:0] idx_reg;
  } fpls_op_t;
endpackage

// File: rtl/fpls_decode.sv
module fpls_decode import fpls_pkg::*; (
  input  logic [31:0]       insn,
  output fpls_op_t          op,
  output logic              legal,
  output logic [2:0]        nwords,
  output logic [15:0]       off_m,
  output logic [RIDX_W-1:0] fgrp
);
  logic [5:0]        opc;
  fpls_size_e        sz;
  logic [15:0]       lowmask;
  logic [RIDX_W-1:0] freg;

  always_comb begin
    opc         = insn[31:26];
    legal       = (opc == OP_FLD_IDX) || (opc == OP_FLD_IMM) ||
                  (opc == OP_FST_IDX) || (opc == OP_FST_IMM);
    op.store    = (opc == OP_FST_IDX) || (opc == OP_FST_IMM);
    op.imm_form = opc[0];
    op.autoinc  = insn[0];
    op.base_reg = insn[25:21];
    op.idx_reg  = insn[15:11];
    freg        = insn[20:16];
    if (insn[1])      sz = SZ_WORD;
    else if (insn[2]) sz = SZ_QUAD;
    else              sz = SZ_PAIR;
    case (sz)
      SZ_WORD: begin nwords = 3'd1; lowmask = 16'hFFFC; end
      SZ_PAIR: begin nwords = 3'd2; lowmask = 16'hFFF8; end
      default: begin nwords = 3'd4; lowmask = 16'hFFF0; end
    endcase
    off_m = insn[15:0] & lowmask;
    fgrp  = freg & ~RIDX_W'(nwords - 3'd1);
  end
endmodule

// File: rtl/fpls_agen.sv
module fpls_agen #(
  parameter int XLEN = 32
) (
  input  logic            imm_form,
  input  logic [15:0]     off_m,
  input  logic [XLEN-1:0] base_val,
  input  logic [XLEN-1:0] idx_val,
  output logic [XLEN-1:0] ea
);
  logic [XLEN-1:0] addend;

  always_comb begin
    addend = imm_form ? {{(XLEN-16){off_m[15]}}, off_m} : idx_val;
    ea     = base_val + addend;
  end
endmodule

// File: rtl/fpls_ctrl.sv
module fpls_ctrl import fpls_pkg::*; #(
  parameter int MAXW  = 4,
  localparam int CNT_W = $clog2(MAXW)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             legal,
  input  logic [CNT_W-1:0] last,
  output fpls_state_e      state,
  output logic [CNT_W-1:0] cnt,
  output logic             accept
);
  assign accept = (state == ST_IDLE) && start && legal;

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE;
      cnt   <= '0;
    end else begin
      case (state)
        ST_IDLE: if (accept) state <= ST_ADDR;
        ST_ADDR: begin
          state <= ST_XFER;
          cnt   <= '0;
        end
        ST_XFER: begin
          if (cnt == last) state <= ST_FIN;
          else             cnt   <= cnt + 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/fpls_seq.sv
module fpls_seq import fpls_pkg::*; #(
  parameter int XLEN = 32,
  parameter int MAXW = 4
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    start,
  input  logic [31:0]             instr,
  output logic                    busy,
  output logic                    done,
  output logic [fpls_pkg::RIDX_W-1:0] int_ra_base,
  output logic [fpls_pkg::RIDX_W-1:0] int_ra_idx,
  input  logic [XLEN-1:0]         int_rd_base,
  input  logic [XLEN-1:0]         int_rd_idx,
  output logic                    int_we,
  output logic [fpls_pkg::RIDX_W-1:0] int_waddr,
  output logic [XLEN-1:0]         int_wdata,
  output logic [fpls_pkg::RIDX_W-1:0] fp_raddr,
  input  logic [XLEN-1:0]         fp_rdata,
  output logic                    fp_we,
  output logic [fpls_pkg::RIDX_W-1:0] fp_waddr,
  output logic [XLEN-1:0]         fp_wdata,
  output logic [XLEN-1:0]         mem_addr,
  output logic                    mem_we,
  output logic [XLEN-1:0]         mem_wdata,
  input  logic [XLEN-1:0]         mem_rdata
);
  localparam int CNT_W = $clog2(MAXW);

  fpls_state_e       state;
  logic [CNT_W-1:0]  cnt;
  logic              accept;
  logic [31:0]       insn_q;
  logic [31:0]       dec_in;
  fpls_op_t          op;
  logic              legal;
  logic [2:0]        nwords;
  logic [15:0]       off_m;
  logic [RIDX_W-1:0] fgrp;
  logic [RIDX_W-1:0] fidx;
  logic [XLEN-1:0]   ea;
  logic [XLEN-1:0]   ea_q;
  logic              xfer;

  assign dec_in = (state == ST_IDLE) ? instr : insn_q;

  fpls_decode u_dec (
    .insn   (dec_in),
    .op     (op),
    .legal  (legal),
    .nwords (nwords),
    .off_m  (off_m),
    .fgrp   (fgrp)
  );

  fpls_agen #(.XLEN(XLEN)) u_agen (
    .imm_form (op.imm_form),
    .off_m    (off_m),
    .base_val (int_rd_base),
    .idx_val  (int_rd_idx),
    .ea       (ea)
  );

  fpls_ctrl #(.MAXW(MAXW)) u_ctrl (
    .clk    (clk),
    .rst    (rst),
    .start  (start),
    .legal  (legal),
    .last   (CNT_W'(nwords - 3'd1)),
    .state  (state),
    .cnt    (cnt),
    .accept (accept)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      insn_q <= '0;
      ea_q   <= '0;
    end else begin
      if (accept)             insn_q <= instr;
      if (state == ST_ADDR)   ea_q   <= ea;
    end
  end

  assign xfer        = (state == ST_XFER);
  assign fidx        = fgrp | {{(RIDX_W-CNT_W){1'b0}}, cnt};
  assign busy        = (state != ST_IDLE);
  assign done        = (state == ST_FIN);
  assign int_ra_base = op.base_reg;
  assign int_ra_idx  = op.idx_reg;
  assign int_we      = done && op.autoinc && (op.base_reg != '0);
  assign int_waddr   = op.base_reg;
  assign int_wdata   = ea_q;
  assign mem_addr    = ea_q + {{(XLEN-CNT_W-2){1'b0}}, cnt, 2'b00};
  assign mem_we      = xfer && op.store;
  assign mem_wdata   = fp_rdata;
  assign fp_raddr    = fidx;
  assign fp_we       = xfer && !op.store;
  assign fp_waddr    = fidx;
  assign fp_wdata    = mem_rdata;
endmodule

// File: rtl/fpls_seq_chk.sv
module fpls_seq_chk #(
  parameter int XLEN = 32
) (
  input logic            clk,
  input logic            rst,
  input logic            start,
  input logic [3:0]      op_hi,
  input logic            busy,
  input logic            done,
  input logic            int_we,
  input logic [4:0]      int_waddr,
  input logic            fp_we,
  input logic            mem_we,
  input logic [XLEN-1:0] mem_addr
);
  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !(mem_we || fp_we || int_we || done));

  a_r2_one_direction: assert property (@(posedge clk) disable iff (rst)
    !(mem_we && fp_we));

  a_r5_word_step: assert property (@(posedge clk) disable iff (rst)
    ((mem_we || fp_we) && $past(mem_we || fp_we)) |-> (mem_addr == $past(mem_addr) + XLEN'(4)));

  a_r6_accept: assert property (@(posedge clk) disable iff (rst)
    (!busy && start && op_hi == 4'h2) |=> busy);

  a_r6_done_pulse: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  a_r7_hold_busy: assert property (@(posedge clk) disable iff (rst)
    (busy && !done) |=> busy);

  a_r8_wb_in_done: assert property (@(posedge clk) disable iff (rst)
    int_we |-> done);

  a_r9_no_base0: assert property (@(posedge clk) disable iff (rst)
    int_we |-> (int_waddr != 5'd0));

  a_r10_illegal_idle: assert property (@(posedge clk) disable iff (rst)
    (!busy && start && op_hi != 4'h2) |=> !busy);
endmodule

bind fpls_seq fpls_seq_chk #(.XLEN(XLEN)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .start     (start),
  .op_hi     (instr[31:28]),
  .busy      (busy),
  .done      (done),
  .int_we    (int_we),
  .int_waddr (int_waddr),
  .fp_we     (fp_we),
  .mem_we    (mem_we),
  .mem_addr  (mem_addr)
);

// File: tb/fpls_seq_tb.sv
`timescale 1ns/1ps
module fpls_seq_tb;
  localparam int XLEN = 32;
  localparam int MWORDS = 1024;
  localparam int NVEC = 8;

  // {instr, expected EA, word count, register group base, write-back expected}
  localparam logic [72:0] VEC [0:NVEC-1] = '{
    {32'h24650012, 32'h00000270, 3'd1, 5'd5,  1'b0},  // load 1w imm, flag bits masked
    {32'h2487FFF0, 32'h00000270, 3'd2, 5'd6,  1'b0},  // load 2w negative imm, odd dest
    {32'h244A0025, 32'h00000260, 3'd4, 5'd8,  1'b1},  // load 4w imm autoinc
    {32'h20233000, 32'h000004E0, 3'd2, 5'd2,  1'b0},  // load 2w indexed
    {32'h2CA9000A, 32'h000002A8, 3'd1, 5'd9,  1'b0},  // store 1w imm
    {32'h28ED1005, 32'h00000520, 3'd4, 5'd12, 1'b1},  // store 4w indexed autoinc
    {32'h2C1F0109, 32'h00000108, 3'd2, 5'd30, 1'b0},  // store 2w autoinc on r0
    {32'h2500FFFF, 32'h000002FC, 3'd1, 5'd0,  1'b1}   // load 1w imm -4 autoinc
  };

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            start = 1'b0;
  logic [31:0]     instr = '0;
  logic            busy, done;
  logic [4:0]      int_ra_base, int_ra_idx, int_waddr, fp_raddr, fp_waddr;
  logic [XLEN-1:0] int_rd_base, int_rd_idx, int_wdata, fp_rdata, fp_wdata;
  logic [XLEN-1:0] mem_addr, mem_wdata, mem_rdata;
  logic            int_we, fp_we, mem_we;

  logic [31:0] bmem [0:MWORDS-1];
  logic [31:0] bfp  [0:31];
  logic [31:0] breg [0:31];
  int          wb_cnt;
  int          n_tests = 0;
  int          n_fail = 0;
  bit          finished = 0;

  always #2.5 clk = ~clk;

  fpls_seq #(.XLEN(XLEN), .MAXW(4)) u_dut (
    .clk(clk), .rst(rst), .start(start), .instr(instr), .busy(busy), .done(done),
    .int_ra_base(int_ra_base), .int_ra_idx(int_ra_idx),
    .int_rd_base(int_rd_base), .int_rd_idx(int_rd_idx),
    .int_we(int_we), .int_waddr(int_waddr), .int_wdata(int_wdata),
    .fp_raddr(fp_raddr), .fp_rdata(fp_rdata),
    .fp_we(fp_we), .fp_waddr(fp_waddr), .fp_wdata(fp_wdata),
    .mem_addr(mem_addr), .mem_we(mem_we), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  assign int_rd_base = breg[int_ra_base];
  assign int_rd_idx  = breg[int_ra_idx];
  assign fp_rdata    = bfp[fp_raddr];
  assign mem_rdata   = bmem[mem_addr[11:2]];

  always @(posedge clk) begin
    if (int_we) begin
      wb_cnt <= wb_cnt + 1;
      if (int_waddr != 5'd0) breg[int_waddr] <= int_wdata;
    end
    if (fp_we)  bfp[fp_waddr] <= fp_wdata;
    if (mem_we) bmem[mem_addr[11:2]] <= mem_wdata;
  end

  function automatic logic [31:0] memv(input int i);
    return 32'hA500_0000 | 32'(i);
  endfunction
  function automatic logic [31:0] fpv(input int k);
    return 32'hF000_005A | (32'(k) << 8);
  endfunction
  function automatic logic [31:0] regv(input int k);
    return (k == 0) ? 32'h0 : 32'h200 + 32'(k) * 32'h20;
  endfunction

  task automatic check(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  endtask

  task automatic init_state();
    for (int i = 0; i < MWORDS; i++) bmem[i] = memv(i);
    for (int k = 0; k < 32; k++) begin
      bfp[k]  = fpv(k);
      breg[k] = regv(k);
    end
    wb_cnt = 0;
  endtask

  task automatic launch(input logic [31:0] ins, output int edges);
    @(negedge clk);
    start = 1'b1;
    instr = ins;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    check(busy == 1'b1, "R6 busy after accept", 32'(busy), 32'd1);
    edges = 0;
    while (!done && edges < 40) begin
      @(posedge clk);
      @(negedge clk);
      edges++;
    end
    @(posedge clk);
    @(negedge clk);
    check(!done && !busy, "R6 done one cycle, busy drops", {30'd0, done, busy}, 32'd0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    init_state();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    check({busy, done, mem_we, fp_we, int_we} == 5'b0, "R1 reset state",
          {27'd0, busy, done, mem_we, fp_we, int_we}, 32'd0);

    // vector table: R2 R3 R4 R5 R6 R8 R9
    for (int v = 0; v < NVEC; v++) begin
      logic [31:0] ins, ea;
      int nw, gb, s2, edges, base;
      logic wb, st;
      ins  = VEC[v][72:41];
      ea   = VEC[v][40:9];
      nw   = int'(VEC[v][8:6]);
      gb   = int'(VEC[v][5:1]);
      wb   = VEC[v][0];
      st   = ins[27];
      s2   = int'(ins[25:21]);
      base = int'(ea[11:2]);
      init_state();
      launch(ins, edges);
      check(edges == nw + 1, "R6 last-word latency", 32'(edges), 32'(nw + 1));
      for (int i = 0; i < nw; i++) begin
        if (st) check(bmem[base + i] == fpv(gb + i), "R2 R3 R5 store word", bmem[base + i], fpv(gb + i));
        else    check(bfp[gb + i] == memv(base + i), "R2 R3 R5 load word", bfp[gb + i], memv(base + i));
      end
      if (st) check(bmem[base + nw] == memv(base + nw), "R4 word past store", bmem[base + nw], memv(base + nw));
      else if (gb + nw < 32) check(bfp[gb + nw] == fpv(gb + nw), "R4 register past load", bfp[gb + nw], fpv(gb + nw));
      if (wb) begin
        check(wb_cnt == 1, "R8 single write-back", 32'(wb_cnt), 32'd1);
        check(breg[s2] == ea, "R8 base gets EA", breg[s2], ea);
      end else begin
        check(wb_cnt == 0, "R8 R9 no write-back", 32'(wb_cnt), 32'd0);
        check(breg[s2] == regv(s2), "R8 R9 base unchanged", breg[s2], regv(s2));
      end
    end

    // R7: start held high with a different store during a load
    begin
      int edges;
      init_state();
      @(negedge clk);
      start = 1'b1;
      instr = VEC[0][72:41];
      @(posedge clk);
      @(negedge clk);
      instr = VEC[4][72:41];
      edges = 0;
      while (!done && edges < 40) begin
        @(posedge clk);
        @(negedge clk);
        edges++;
      end
      start = 1'b0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      check(busy == 1'b0, "R7 no second transfer", 32'(busy), 32'd0);
      check(bfp[5] == memv(32'h9C), "R7 first load done", bfp[5], memv(32'h9C));
      check(bmem[32'hAA] == memv(32'hAA), "R7 ignored store absent", bmem[32'hAA], memv(32'hAA));
    end

    // R10: unknown opcode 0x05
    init_state();
    @(negedge clk);
    start = 1'b1;
    instr = 32'h14650012;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    check(busy == 1'b0, "R10 stays idle", 32'(busy), 32'd0);
    repeat (4) @(posedge clk);
    @(negedge clk);
    check(bfp[5] == fpv(5) && breg[3] == regv(3) && wb_cnt == 0, "R10 no effect", bfp[5], fpv(5));

    finish_run();
  end
endmodule